// File: doc/BRIEF.md
# Serial Read Path with Streaming Word Output

This block is the data-out side of a three-wire serial memory slave. A decoder outside this block recognises a memory read or a protect-address read. It presents that request for one serial clock, together with the address to start from. The block then drives the serial output pin. It sends one zero bit first, then the requested content, most significant bit first, with one bit for each rising edge of the serial clock.

For memory reads, the words come from a synchronous-read array port. While chip select stays high and the serial clock keeps running, the block moves on to the following address at the end of each word. The next word starts on the very next bit period, with no extra zero in between. After the highest address the stream continues at address zero. To keep the stream gap-free, each following word is fetched while the last bit of the current word is on the pin.

A protect-address read sends the stored boundary address instead, also behind one zero bit. It then lets go of the pin. Lowering chip select at any point ends the transfer and releases the output at once.

Top module: `serial_read_path`

## Requirements
- R1: While reset is active and after it is released, with no request given, `dout_en` and `mem_rd_en` are both low.
- R2: A request (`start` high while `cs` is high and the block is idle) makes the block drive `dout` to 0 for the bit period that follows that rising edge of `sk`.
- R3: For a memory read, the 16-bit word at `start_addr` follows the zero bit, most significant bit first. Each later rising edge of `sk` presents the next bit.
- R4: Right after bit 0 of a word, bit 15 of the word at the next higher address appears, with no zero bit inserted between words.
- R5: The address after the highest register (AW bits all ones) is register 0.
- R6: With `prot_sel` high at the request, the AW-bit `prot_addr` follows the zero bit, most significant bit first. On the next edge `dout_en` falls even though `cs` stays high, and `mem_rd_en` stays low for the whole transfer.
- R7: `dout_en` goes low as soon as `cs` is low, without waiting for a clock. The transfer is abandoned: raising `cs` again without a request leaves `dout_en` low, and a new request starts again with a zero bit.
- R8: A `start` pulse that arrives while a transfer is running has no effect on the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select, high for an active transfer |
| start | input | 1 | Decoded read request, one serial clock wide |
| prot_sel | input | 1 | With `start`: 1 reads the protect address, 0 reads the array |
| start_addr | input | AW | First array register to send |
| prot_addr | input | AW | Stored protect boundary address |
| mem_rd_en | output | 1 | Array read strobe; data is valid after the next rising edge |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | DW | Array read data |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Output enable for the serial pin; low means high impedance |

## Verification
Array reads of three words start from every one of the 64 addresses. Each word holds an arithmetic pattern that differs per address, so a wrong start address, a wrong bit order or a wrong step to the next word shows up at once. The sweeps that begin at addresses 62 and 63 cross the top of the array, and a longer stream runs through the boundary. Together they separate the wrap to zero from a stall or a jump past it. Every protect value from 0 to 63 is read, which catches a wrong field width or an off-by-one in the release point. An aborted transfer and a `start` pulse in the middle of a stream check that dropping chip select resets the sequence, and that a request is only taken when the block is idle.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DUMMY = 2'd1,
    ST_DATA  = 2'd2
  } srd_state_e;
endpackage

// File: rtl/srd_rst_sync.sv
module srd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/srd_addr_ctr.sv
module srd_addr_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr_nxt
);
  logic [AW-1:0] addr_d;

  // power-of-two depth: the add wraps the top register to zero
  assign addr_nxt = addr + AW'(1);

  always_comb begin
    addr_d = addr;
    if (load)     addr_d = load_val;
    else if (inc) addr_d = addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr <= '0;
    else if (load || inc) addr <= addr_d;
  end

  // R5
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && addr == {AW{1'b1}}) |=> (addr == '0));
endmodule

// File: rtl/srd_shifter.sv
module srd_shifter #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift_en,
  output logic          msb,
  output logic [CW-1:0] cnt
);
  logic [DW-1:0] sreg, sreg_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    sreg_d = sreg;
    cnt_d  = cnt;
    if (load) begin
      sreg_d = load_val;
      cnt_d  = '0;
    end else if (shift_en) begin
      sreg_d = {sreg[DW-2:0], 1'b0};
      cnt_d  = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load || shift_en) begin
      sreg <= sreg_d;
      cnt  <= cnt_d;
    end
  end

  assign msb = sreg[DW-1];

  // R3
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load) |=> (msb == $past(sreg[DW-2])));
endmodule

// File: rtl/serial_read_path.sv
module serial_read_path
  import srd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          sk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          start,
  input  logic          prot_sel,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] prot_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          dout,
  output logic          dout_en
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_W = CW'(DW - 1);
  localparam logic [CW-1:0] PRE_W  = CW'(DW - 2);
  localparam logic [CW-1:0] LAST_P = CW'(AW - 1);

  logic          rst_q;
  srd_state_e    st_q, st_d;
  logic          prot_q, prot_d;
  logic          word_end, take_req;
  logic          sh_load, sh_shift, sh_msb;
  logic [CW-1:0] sh_cnt;
  logic [DW-1:0] sh_val;
  logic          ad_inc;
  logic [AW-1:0] ad_q, ad_nxt;

  srd_rst_sync u_rst (.clk(sk), .rst_n(rst_n), .rst_q(rst_q));

  assign take_req = cs && (st_q == ST_IDLE) && start;
  assign word_end = (st_q == ST_DATA) && (sh_cnt == (prot_q ? LAST_P : LAST_W));

  // next state
  always_comb begin
    st_d   = st_q;
    prot_d = prot_q;
    if (!cs) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start) begin
                    st_d   = ST_DUMMY;
                    prot_d = prot_sel;
                  end
        ST_DUMMY: st_d = ST_DATA;
        ST_DATA:  if (word_end && prot_q) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge sk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      prot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prot_q <= prot_d;
    end
  end

  // shifter control: first load after the zero bit, later loads back to back
  assign sh_load  = cs && ((st_q == ST_DUMMY) || (word_end && !prot_q));
  assign sh_shift = cs && (st_q == ST_DATA) && !word_end;
  assign sh_val   = prot_q ? {prot_addr, {(DW-AW){1'b0}}} : mem_rdata;
  assign ad_inc   = cs && word_end && !prot_q;

  srd_shifter #(.DW(DW)) u_shift (
    .clk(sk), .rst_n(rst_q), .load(sh_load), .load_val(sh_val),
    .shift_en(sh_shift), .msb(sh_msb), .cnt(sh_cnt)
  );

  srd_addr_ctr #(.AW(AW)) u_addr (
    .clk(sk), .rst_n(rst_q), .load(take_req), .load_val(start_addr),
    .inc(ad_inc), .addr(ad_q), .addr_nxt(ad_nxt)
  );

  // array fetch: on the request, and again so data lands in the last bit period
  assign mem_rd_en = (take_req && !prot_sel) ||
                     (cs && (st_q == ST_DATA) && !prot_q && (sh_cnt == PRE_W));
  assign mem_addr  = (st_q == ST_IDLE) ? start_addr : ad_nxt;

  assign dout    = (st_q == ST_DATA) && sh_msb;
  assign dout_en = cs && (st_q != ST_IDLE);

  // R2
  dummy_zero_chk: assert property (@(posedge sk) disable iff (!rst_q)
    take_req |=> (!cs || (dout_en && !dout)));

  // R6
  prot_noread_chk: assert property (@(posedge sk) disable iff (!rst_q)
    (prot_q && st_q != ST_IDLE) |-> !mem_rd_en);

  // R7
  cs_idle_chk: assert property (@(posedge sk) disable iff (!rst_q)
    !cs |=> (st_q == ST_IDLE));

  // R8
  busy_start_chk: assert property (@(posedge sk) disable iff (!rst_q)
    (cs && start && st_q == ST_DATA && !prot_q) |=> (!cs || st_q == ST_DATA));
endmodule

// File: tb/tb_serial_read_path.sv
module tb_serial_read_path;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int PER = 10;

  logic          sk = 1'b0;
  logic          rst_n, cs, start, prot_sel;
  logic [AW-1:0] start_addr, prot_addr;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          dout, dout_en;
  int            n_chk = 0;
  int            n_bad = 0;

  always #(PER/2) sk = ~sk;

  serial_read_path #(.DW(DW), .AW(AW)) dut (
    .sk(sk), .rst_n(rst_n), .cs(cs), .start(start), .prot_sel(prot_sel),
    .start_addr(start_addr), .prot_addr(prot_addr), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] word_at(int a);
    return DW'((a * 40503 + 4660) ^ 23130);
  endfunction

  always @(posedge sk) if (mem_rd_en) mem_rdata <= word_at(int'(mem_addr));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // glitch >= 0: pulse start at that bit index of the stream
  task automatic array_read(int a, int words, int glitch);
    @(negedge sk);
    cs = 1; start = 1; prot_sel = 0; start_addr = AW'(a);
    @(negedge sk);
    start = 0; start_addr = AW'(a + 17);
    check(dout_en == 1 && dout == 0, "R2", {dout_en, dout}, 2);
    for (int n = 0; n < words; n++) begin
      for (int j = DW - 1; j >= 0; j--) begin
        int k = n * DW + (DW - 1 - j);
        bit e = word_at((a + n) % 64)[j];
        start = (k == glitch);
        @(negedge sk);
        start = 0;
        if (glitch >= 0)
          check(dout == e && dout_en, "R8", dout, e);
        else if (n == 0)
          check(dout == e && dout_en, "R3", dout, e);
        else if (a + n >= 64)
          check(dout == e && dout_en, "R5", dout, e);
        else
          check(dout == e && dout_en, "R4", dout, e);
      end
    end
    cs = 0;
    #1 check(dout_en == 0, "R7", dout_en, 0);
  endtask

  task automatic prot_read(int p);
    @(negedge sk);
    cs = 1; start = 1; prot_sel = 1; prot_addr = AW'(p);
    #1 check(mem_rd_en == 0, "R6", mem_rd_en, 0);
    @(negedge sk);
    start = 0; prot_sel = 0;
    check(dout_en == 1 && dout == 0, "R2", {dout_en, dout}, 2);
    for (int j = AW - 1; j >= 0; j--) begin
      @(negedge sk);
      check(dout == p[j] && dout_en && !mem_rd_en, "R6", dout, p[j]);
    end
    @(negedge sk);
    check(dout_en == 0, "R6", dout_en, 0);
    cs = 0;
  endtask

  initial begin
    #(PER * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; cs = 0; start = 0; prot_sel = 0;
    start_addr = '0; prot_addr = '0;
    repeat (3) @(negedge sk);
    check(dout_en == 0 && mem_rd_en == 0, "R1", {dout_en, mem_rd_en}, 0);
    rst_n = 1;
    repeat (4) @(negedge sk);
    check(dout_en == 0 && mem_rd_en == 0, "R1", {dout_en, mem_rd_en}, 0);

    for (int a = 0; a < 64; a++) array_read(a, 3, -1);
    array_read(60, 8, -1);
    array_read(9, 3, 21);

    for (int p = 0; p < 64; p++) prot_read(p);

    // abort in the middle of a word, then idle with cs high
    @(negedge sk);
    cs = 1; start = 1; prot_sel = 0; start_addr = AW'(5);
    @(negedge sk);
    start = 0;
    repeat (7) @(negedge sk);
    cs = 0;
    #1 check(dout_en == 0, "R7", dout_en, 0);
    repeat (2) @(negedge sk);
    cs = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge sk);
      check(dout_en == 0, "R7", dout_en, 0);
    end
    cs = 0;
    array_read(5, 2, -1);

    repeat (2) @(negedge sk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule